// File: doc/BRIEF.md
# Remote Operand Buffer with Sticky Stack-Pointer Entries

In a clustered out-of-order core, an instruction may need a source operand that lives in the physical register file of another cluster. This block is the small per-cluster store for such operands. Once a value has arrived, local consumers read it from here instead of requesting another transfer between clusters. An entry is reserved through the allocate port, tagged with a physical register number. It becomes ready when a fill (from the intercluster data bus or from local writeback) carries that tag. Consumers then find it through an associative lookup on the tag.

The entries form two pools. Ordinary operands use the general pool, and an ordinary entry is released once a consumer has read a ready value from it. Stack-pointer references use a separate, smaller pool and are allocated eagerly, before their value exists. When the producing instruction completes, its writeback fills the entry. A stack-pointer entry is sticky: reads never release it, so every later reader of the same stack-pointer value still hits. A sticky entry leaves only when a newer stack-pointer allocation takes its slot, or on a flush.

Top module: `remote_operand_buf`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, no entry is valid and every lookup misses. During a flush cycle, allocation has no effect and `alloc_stall` is 0.
- R2: A general allocation (`alloc_sp`=0) whose tag is not present takes the lowest-numbered free general entry. The entry is valid and not ready, so a lookup of that tag gives `lkp_hit`=1 and `lkp_ready`=0.
- R3: An allocation whose tag already sits in a valid entry of either pool creates no second entry. It drives `alloc_stall`=0 even when the required pool is full.
- R4: With all 4 general entries valid, a general allocation of a new tag drives `alloc_stall`=1 in the same cycle and changes no entry.
- R5: A fill whose tag matches a valid entry sets that entry ready and stores `fill_data`. A fill that matches no entry is ignored.
- R6: When a lookup and a fill carry the same tag in one cycle and the tag hits, the lookup returns `lkp_ready`=1 with `lkp_data` equal to `fill_data`.
- R7: A general entry that a lookup hits with `lkp_ready`=1 is gone from the next cycle on. The exception is an allocation of the same tag in that same cycle, which keeps the entry.
- R8: A stack-pointer entry stays valid and keeps its value across any number of ready lookups. Only a flush or a stack-pointer allocation removes it.
- R9: A stack-pointer allocation (`alloc_sp`=1) of a new tag uses the 2-entry stack-pointer pool. It takes a free entry if one exists. Otherwise it replaces the oldest stack-pointer allocation if that entry is ready, and if that entry is not ready it drives `alloc_stall`=1 and changes nothing.
- R10: `lkp_hit`, `lkp_ready` and `lkp_data` respond in the same cycle as the lookup request. On a miss, `lkp_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush; invalidates all entries |
| alloc_valid | input | 1 | Allocation request |
| alloc_sp | input | 1 | Allocation is a stack-pointer reference |
| alloc_tag | input | 6 | Physical register tag to allocate |
| alloc_stall | output | 1 | Allocation cannot be accepted this cycle |
| fill_valid | input | 1 | Fill (bus or writeback) present |
| fill_tag | input | 6 | Tag of the fill |
| fill_data | input | 32 | Operand value of the fill |
| lkp_valid | input | 1 | Consumer lookup request |
| lkp_tag | input | 6 | Tag being looked up |
| lkp_hit | output | 1 | A valid entry holds the tag |
| lkp_ready | output | 1 | The hit entry has its value |
| lkp_data | output | 32 | Operand value (forwarded fill when same cycle) |

## Verification
The assertions check four properties on every cycle. Tags stay unique across entries. A flush empties the buffer. A stalled allocation never adds an entry. A ready read of a general entry releases it, while stack-pointer entries survive everything except a flush or a stack-pointer allocation. The bench scenarios cover what needs a specific history to observe. They show which slot is chosen and which sticky entry is the oldest victim. They show the stall that occurs when that victim is not ready, and the same-cycle forwarding from fill to lookup. They also show that an allocation arriving with a releasing read keeps the entry alive, and that values seen at the port are correct.

// File: rtl/rop_pkg.sv
package rop_pkg;
    localparam int ROP_TAG_W  = 6;
    localparam int ROP_DATA_W = 32;

    typedef struct packed {
        logic                  valid;
        logic                  ready;
        logic                  sticky;
        logic [ROP_TAG_W-1:0]  tag;
        logic [ROP_DATA_W-1:0] data;
    } rop_entry_t;
endpackage

// File: rtl/rop_tag_match.sv
module rop_tag_match #(
    parameter int N  = 6,
    parameter int TW = 6
) (
    input  logic [N-1:0]    valid,
    input  logic [N*TW-1:0] tags,
    input  logic [TW-1:0]   key,
    output logic [N-1:0]    hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = valid[i] && (tags[i*TW +: TW] == key);
    end
endmodule

// File: rtl/rop_free_pick.sv
module rop_free_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/remote_operand_buf.sv
module remote_operand_buf
    import rop_pkg::*;
#(
    parameter int GEN_N = 4,
    parameter int SP_N  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  alloc_valid,
    input  logic                  alloc_sp,
    input  logic [ROP_TAG_W-1:0]  alloc_tag,
    output logic                  alloc_stall,
    input  logic                  fill_valid,
    input  logic [ROP_TAG_W-1:0]  fill_tag,
    input  logic [ROP_DATA_W-1:0] fill_data,
    input  logic                  lkp_valid,
    input  logic [ROP_TAG_W-1:0]  lkp_tag,
    output logic                  lkp_hit,
    output logic                  lkp_ready,
    output logic [ROP_DATA_W-1:0] lkp_data
);
    localparam int TOT   = GEN_N + SP_N;
    localparam int IDX_W = (TOT > 1) ? $clog2(TOT) : 1;
    localparam int GW    = (GEN_N > 1) ? $clog2(GEN_N) : 1;
    localparam int SPW   = (SP_N > 1) ? $clog2(SP_N) : 1;

    typedef struct packed {
        rop_entry_t [TOT-1:0] ent;
        logic [SPW-1:0]       ptr;   // oldest stack-pointer slot
    } rop_state_t;

    rop_state_t st_d, st_q;

    logic [TOT-1:0]           v_q, r_q, s_q;
    logic [TOT*ROP_TAG_W-1:0] tags_flat;
    logic [TOT-1:0]           lk_hit, fl_hit, al_hit;
    logic                     g_found, s_found;
    logic [GW-1:0]            g_idx;
    logic [SPW-1:0]           s_idx;
    logic                     fwd;

    for (genvar i = 0; i < TOT; i++) begin : g_unpack
        assign v_q[i] = st_q.ent[i].valid;
        assign r_q[i] = st_q.ent[i].ready;
        assign s_q[i] = st_q.ent[i].sticky;
        assign tags_flat[i*ROP_TAG_W +: ROP_TAG_W] = st_q.ent[i].tag;
    end

    rop_tag_match #(.N(TOT), .TW(ROP_TAG_W)) u_lk_match (
        .valid(v_q), .tags(tags_flat), .key(lkp_tag), .hit(lk_hit));
    rop_tag_match #(.N(TOT), .TW(ROP_TAG_W)) u_fl_match (
        .valid(v_q), .tags(tags_flat), .key(fill_tag), .hit(fl_hit));
    rop_tag_match #(.N(TOT), .TW(ROP_TAG_W)) u_al_match (
        .valid(v_q), .tags(tags_flat), .key(alloc_tag), .hit(al_hit));

    rop_free_pick #(.N(GEN_N), .IW(GW)) u_gen_pick (
        .busy(v_q[GEN_N-1:0]), .found(g_found), .idx(g_idx));
    rop_free_pick #(.N(SP_N), .IW(SPW)) u_sp_pick (
        .busy(v_q[TOT-1:GEN_N]), .found(s_found), .idx(s_idx));

    // Lookup port: same-cycle result, fill data forwarded on tag match
    always_comb begin
        fwd       = fill_valid && (fill_tag == lkp_tag);
        lkp_hit   = lkp_valid && (|lk_hit);
        lkp_ready = lkp_hit && (fwd || (|(lk_hit & r_q)));
        lkp_data  = '0;
        if (lkp_hit) begin
            if (fwd) begin
                lkp_data = fill_data;
            end else begin
                for (int i = 0; i < TOT; i++) begin
                    if (lk_hit[i]) lkp_data = lkp_data | st_q.ent[i].data;
                end
            end
        end
    end

    // Next-state computation
    always_comb begin
        rop_entry_t       new_e;
        logic [SPW-1:0]   slot;
        logic [IDX_W-1:0] wslot;
        logic             sp_ok;

        st_d        = st_q;
        alloc_stall = 1'b0;
        slot        = s_idx;
        sp_ok       = 1'b0;
        wslot       = '0;

        new_e        = '0;
        new_e.valid  = 1'b1;
        new_e.sticky = alloc_sp;
        new_e.tag    = alloc_tag;

        for (int i = 0; i < TOT; i++) begin
            if (fill_valid && fl_hit[i]) begin
                st_d.ent[i].ready = 1'b1;
                st_d.ent[i].data  = fill_data;
            end
        end

        for (int i = 0; i < TOT; i++) begin
            if (lkp_ready && lk_hit[i] && !s_q[i] && !(alloc_valid && al_hit[i])) begin
                st_d.ent[i].valid = 1'b0;
            end
        end

        if (alloc_valid && !(|al_hit)) begin
            if (!alloc_sp) begin
                if (g_found) st_d.ent[IDX_W'(g_idx)] = new_e;
                else         alloc_stall = 1'b1;
            end else begin
                if (s_found) begin
                    slot  = s_idx;
                    sp_ok = 1'b1;
                end else if (r_q[IDX_W'(GEN_N) + IDX_W'(st_q.ptr)]) begin
                    slot  = st_q.ptr;
                    sp_ok = 1'b1;
                end else begin
                    alloc_stall = 1'b1;
                end
                if (sp_ok) begin
                    wslot           = IDX_W'(GEN_N) + IDX_W'(slot);
                    st_d.ent[wslot] = new_e;
                    st_d.ptr        = (slot == SPW'(SP_N - 1)) ? '0 : slot + 1'b1;
                end
            end
        end

        if (flush) begin
            st_d        = '0;
            alloc_stall = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Assertions
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (v_q == '0)); // R1

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit)); // R3

    AST_STALL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_stall) |=> ($countones(v_q) <= $past($countones(v_q)))); // R4

    AST_GEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_ready && (|lk_hit[GEN_N-1:0]) && !(alloc_valid && alloc_tag == lkp_tag))
        |=> ((v_q[GEN_N-1:0] & $past(lk_hit[GEN_N-1:0])) == '0)); // R7

    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !(alloc_valid && alloc_sp))
        |=> ((v_q[TOT-1:GEN_N] & $past(v_q[TOT-1:GEN_N])) == $past(v_q[TOT-1:GEN_N]))); // R8
endmodule

// File: tb/remote_operand_buf_test.sv
module remote_operand_buf_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        alloc_valid = 1'b0, alloc_sp = 1'b0;
    logic [5:0]  alloc_tag = '0;
    logic        alloc_stall;
    logic        fill_valid = 1'b0;
    logic [5:0]  fill_tag = '0;
    logic [31:0] fill_data = '0;
    logic        lkp_valid = 1'b0;
    logic [5:0]  lkp_tag = '0;
    logic        lkp_hit, lkp_ready;
    logic [31:0] lkp_data;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    typedef struct {
        bit          chk_stall;
        bit          stall;
        string       s_req;
        bit          chk_lk;
        bit          hit;
        bit          rdy;
        logic [31:0] data;
        string       l_req;
    } exp_t;

    exp_t q[$];
    exp_t pend;

    always #(CLK_PERIOD / 2) clk = ~clk;

    remote_operand_buf uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_sp(alloc_sp), .alloc_tag(alloc_tag),
        .alloc_stall(alloc_stall),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .lkp_valid(lkp_valid), .lkp_tag(lkp_tag),
        .lkp_hit(lkp_hit), .lkp_ready(lkp_ready), .lkp_data(lkp_data));

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (rst_n && (alloc_valid || lkp_valid)) begin
            if (q.size() == 0) begin
                check(1'b0, "scoreboard", "unexpected activity", 0, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.chk_stall)
                    check(alloc_stall == e.stall, e.s_req, "alloc_stall", alloc_stall, e.stall);
                if (e.chk_lk) begin
                    check(lkp_hit == e.hit, e.l_req, "lkp_hit", lkp_hit, e.hit);
                    if (e.hit)
                        check(lkp_ready == e.rdy, e.l_req, "lkp_ready", lkp_ready, e.rdy);
                    if (!e.hit || e.rdy)
                        check(lkp_data == e.data, e.l_req, "lkp_data", lkp_data, e.data);
                end
            end
        end
    end

    // Driver tasks
    task automatic do_alloc(bit sp, logic [5:0] tag, bit exp_stall, string req);
        alloc_valid = 1'b1; alloc_sp = sp; alloc_tag = tag;
        pend.chk_stall = 1'b1; pend.stall = exp_stall; pend.s_req = req;
    endtask

    task automatic do_fill(logic [5:0] tag, logic [31:0] d);
        fill_valid = 1'b1; fill_tag = tag; fill_data = d;
    endtask

    task automatic do_look(logic [5:0] tag, bit hit, bit rdy, logic [31:0] d, string req);
        lkp_valid = 1'b1; lkp_tag = tag;
        pend.chk_lk = 1'b1; pend.hit = hit; pend.rdy = rdy; pend.data = d; pend.l_req = req;
    endtask

    task automatic tick();
        if (pend.chk_stall || pend.chk_lk) q.push_back(pend);
        @(posedge clk);
        #1;
        alloc_valid = 1'b0; alloc_sp = 1'b0; fill_valid = 1'b0;
        lkp_valid = 1'b0; flush = 1'b0;
        pend = '{default: 0, s_req: "", l_req: ""};
    endtask

    initial begin
        pend = '{default: 0, s_req: "", l_req: ""};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        do_look(6'd5, 0, 0, 0, "R1 reset"); tick();
        // R2: allocate, not ready
        do_alloc(0, 6'd10, 0, "R2 alloc"); tick();
        do_look(6'd10, 1, 0, 0, "R2 not ready"); tick();
        // R6: forward fill to lookup; R10 same-cycle response
        do_fill(6'd10, 32'hA0A0_0001); do_look(6'd10, 1, 1, 32'hA0A0_0001, "R6 forward"); tick();
        // R7: released after ready read; R10 zero data on miss
        do_look(6'd10, 0, 0, 0, "R7 released"); tick();
        // R5: fill then read
        do_alloc(0, 6'd11, 0, "R2 alloc 11"); tick();
        do_fill(6'd11, 32'hB0B0_0002); tick();
        do_look(6'd11, 1, 1, 32'hB0B0_0002, "R5 fill stored"); tick();
        do_look(6'd11, 0, 0, 0, "R7 released 11"); tick();
        // R5: fill with unknown tag ignored
        do_fill(6'd20, 32'h1234_5678); tick();
        do_look(6'd20, 0, 0, 0, "R5 fill ignored"); tick();
        // R4: fill the general pool
        for (int t = 1; t <= 4; t++) begin
            do_alloc(0, 6'(t), 0, "R2 fill pool"); tick();
        end
        do_alloc(0, 6'd5, 1, "R4 full stall"); tick();
        do_look(6'd5, 0, 0, 0, "R4 no change"); tick();
        // R3: reuse while full
        do_alloc(0, 6'd3, 0, "R3 reuse no stall"); tick();
        do_fill(6'd1, 32'h0000_00C1); do_look(6'd1, 1, 1, 32'h0000_00C1, "R6 forward 1"); tick();
        do_alloc(0, 6'd5, 0, "R7 slot freed"); tick();
        do_alloc(0, 6'd6, 1, "R4 full again"); tick();
        // R9 / R8: stack-pointer pool
        do_alloc(1, 6'd40, 0, "R9 sp alloc"); tick();
        do_look(6'd40, 1, 0, 0, "R9 sp not ready"); tick();
        do_fill(6'd40, 32'h5050_0040); tick();
        do_look(6'd40, 1, 1, 32'h5050_0040, "R8 sp read 1"); tick();
        do_look(6'd40, 1, 1, 32'h5050_0040, "R8 sp read 2"); tick();
        do_look(6'd40, 1, 1, 32'h5050_0040, "R8 sp read 3"); tick();
        do_alloc(1, 6'd41, 0, "R9 sp second"); tick();
        do_alloc(1, 6'd42, 0, "R9 replace oldest ready"); tick();
        do_look(6'd40, 0, 0, 0, "R9 oldest replaced"); tick();
        do_look(6'd41, 1, 0, 0, "R9 other kept"); tick();
        do_alloc(1, 6'd43, 1, "R9 victim not ready stall"); tick();
        do_look(6'd42, 1, 0, 0, "R9 stall no change"); tick();
        do_fill(6'd41, 32'hD0D0_0041); tick();
        do_alloc(1, 6'd43, 0, "R9 replace after ready"); tick();
        do_look(6'd41, 0, 0, 0, "R9 41 replaced"); tick();
        do_look(6'd43, 1, 0, 0, "R9 43 present"); tick();
        do_alloc(1, 6'd42, 0, "R3 sp reuse"); tick();
        do_look(6'd2, 1, 0, 0, "R4 general kept"); tick();
        // R1: flush
        flush = 1'b1; tick();
        do_look(6'd2, 0, 0, 0, "R1 flush general"); tick();
        do_look(6'd42, 0, 0, 0, "R1 flush sp"); tick();
        flush = 1'b1; do_alloc(0, 6'd9, 0, "R1 alloc during flush"); tick();
        do_look(6'd9, 0, 0, 0, "R1 flush blocks alloc"); tick();
        // R7: allocation in the releasing cycle keeps the entry
        do_alloc(0, 6'd7, 0, "R2 alloc 7"); tick();
        do_fill(6'd7, 32'hE0E0_0007); tick();
        do_look(6'd7, 1, 1, 32'hE0E0_0007, "R7 read with alloc"); do_alloc(0, 6'd7, 0, "R3 realloc 7"); tick();
        do_look(6'd7, 1, 1, 32'hE0E0_0007, "R7 kept by alloc"); tick();
        do_look(6'd7, 0, 0, 0, "R7 released later"); tick();
        // R8: sticky after flush refill
        do_alloc(1, 6'd50, 0, "R9 sp after flush"); tick();
        do_fill(6'd50, 32'hF0F0_0050); do_look(6'd50, 1, 1, 32'hF0F0_0050, "R6 sp forward"); tick();
        do_look(6'd50, 1, 1, 32'hF0F0_0050, "R8 sp sticky"); tick();
        tick();
        check(q.size() == 0, "scoreboard", "queue drained", q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule